// File: doc/BRIEF.md
# Page-Mapping Address Translation Unit

This block extends the 16-bit logical address of an 8-bit processor to a 24-bit physical address. The logical space is cut into sixteen 4 KiB pages. The top four logical address bits pick one of sixteen table entries. The 12-bit frame held in that entry becomes the upper part of the physical address, and the 12-bit offset within the page passes straight through. Lookup is combinational, so the physical address follows the logical address in the same cycle.

Software fills the table with I/O write cycles on two adjacent port numbers. During such a cycle the low address byte carries the port number. The upper address byte carries an index in its top four bits, so software steps through the entries by adding 0x10 to the upper byte. One port loads the low eight bits of the addressed entry and the next port loads its top four bits. The storage drives out the one's complement of what was written, so software writes the inverted frame number. The table cannot be read back. Reset does not initialise it, and software must load every entry before memory accesses through it mean anything.

Top module: `page_xlate`

## Requirements
- R1: `phys_addr[23:12]` equals the frame held by the entry that `cpu_addr[15:12]` selects. It changes only when `cpu_addr` changes or a table write occurs.
- R2: `phys_addr[11:0]` always equals `cpu_addr[11:0]`, in reset and out of it.
- R3: A clock edge with `rst_n`, `io_req` and `wr_req` all high and `cpu_addr[7:0]` equal to `PORT_BASE` (default 0x60) stores `cpu_data[7:0]` as bits [7:0] of entry `cpu_addr[15:12]`. `cpu_addr[11:8]` plays no part in choosing the entry.
- R4: The same kind of edge with `cpu_addr[7:0]` equal to `PORT_BASE+1` (default 0x61) stores `cpu_data[3:0]` as bits [11:8] of the entry. `cpu_data[7:4]` is ignored.
- R5: A write to one half of an entry leaves the other half of that entry, and every other entry, unchanged.
- R6: The frame seen on `phys_addr[23:12]` is the bitwise complement of the stored bits, so writing ~N to both halves maps the page to frame N.
- R7: No entry changes on an edge where `rst_n` is low, `io_req` is low or `wr_req` is low, or where `cpu_addr[7:0]` matches neither port. Reset itself leaves stored entries as they are.
- R8: A write to the entry that a later cycle addresses shows on `phys_addr` in the first cycle after the write edge.

Ports

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; table writes occur on its rising edge |
| rst_n | input | 1 | Active-low reset; blocks table writes while low |
| cpu_addr | input | 16 | Processor address: logical address for memory, index and port number for I/O |
| cpu_data | input | 8 | Processor write data |
| io_req | input | 1 | High during an I/O cycle |
| wr_req | input | 1 | High during a write cycle |
| phys_addr | output | 24 | Translated physical address |

## Verification
A corrupted or wrongly indexed entry shows only when software next touches the page it maps. The upper twelve `phys_addr` bits are then wrong in that same cycle, and every other page looks correct. The bench therefore walks every page after each change to the table. A write that lands in the wrong half, or in a neighbouring entry, shows up in the first lookup after the edge. A write that should have been blocked shows up as an unexpected frame on the page it hit.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

   // Which half of a table entry an I/O write cycle targets
   typedef enum logic [1:0] {
      HALF_NONE = 2'd0,
      HALF_LO   = 2'd1,
      HALF_HI   = 2'd2
   } half_e;

endpackage

// File: rtl/xlate_port_decode.sv
module xlate_port_decode
   import xlate_pkg::*;
#(
   parameter int unsigned              SEL_W     = 4,
   parameter int unsigned              PORT_W    = 8,
   parameter logic [PORT_W-1:0]        PORT_BASE = 8'h60
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              io_req,
   input  logic              wr_req,
   input  logic [PORT_W-1:0] port,
   input  logic [SEL_W-1:0]  sel_in,
   output logic              wr_lo,
   output logic              wr_hi,
   output logic [SEL_W-1:0]  wr_idx
);

   localparam logic [PORT_W-1:0] PORT_LO = PORT_BASE;
   localparam logic [PORT_W-1:0] PORT_HI = PORT_W'(PORT_BASE + 1'b1);

   if (PORT_BASE == {PORT_W{1'b1}}) begin : g_bad_base
      $error("xlate_port_decode: PORT_BASE leaves no room for the upper-half port");
   end

   half_e half;
   logic  cycle_ok;

   assign cycle_ok = rst_n & io_req & wr_req;

   always_comb begin
      half = HALF_NONE;
      if (cycle_ok) begin
         if (port == PORT_LO)      half = HALF_LO;
         else if (port == PORT_HI) half = HALF_HI;
      end
   end

   assign wr_lo  = (half == HALF_LO);
   assign wr_hi  = (half == HALF_HI);
   assign wr_idx = sel_in;

   // R7: an unqualified cycle must never raise a write enable
   assert_blocked_R7: assert property (@(posedge clk)
      (!io_req || !wr_req || !rst_n) |-> (!wr_lo && !wr_hi));

endmodule

// File: rtl/xlate_frame_table.sv
module xlate_frame_table #(
   parameter int unsigned SEL_W   = 4,
   parameter int unsigned FRAME_W = 12,
   parameter int unsigned DATA_W  = 8,
   parameter bit          INVERT  = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_lo,
   input  logic               wr_hi,
   input  logic [SEL_W-1:0]   wr_idx,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic [SEL_W-1:0]   rd_idx,
   output logic [FRAME_W-1:0] rd_frame
);

   localparam int unsigned ENTRIES = 1 << SEL_W;
   localparam int unsigned LO_W    = DATA_W;
   localparam int unsigned HI_W    = FRAME_W - DATA_W;

   if (FRAME_W <= DATA_W || FRAME_W > 2 * DATA_W) begin : g_bad_width
      $error("xlate_frame_table: FRAME_W must need exactly two data writes");
   end

   logic [LO_W-1:0] lo_q [ENTRIES];
   logic [HI_W-1:0] hi_q [ENTRIES];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
      always_ff @(posedge clk) begin
         if (wr_lo && (wr_idx == SEL_W'(e))) lo_q[e] <= wr_data;
         if (wr_hi && (wr_idx == SEL_W'(e))) hi_q[e] <= wr_data[HI_W-1:0];
      end
   end

   logic [FRAME_W-1:0] raw;
   assign raw = {hi_q[rd_idx], lo_q[rd_idx]};

   if (INVERT) begin : g_inv
      assign rd_frame = ~raw;
   end else begin : g_true
      assign rd_frame = raw;
   end

   // R3: low-half write stores the data byte at the addressed entry
   assert_lo_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wr_lo |=> (lo_q[$past(wr_idx)] == $past(wr_data)));

   // R4: upper-half write stores only the low data bits
   assert_hi_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hi |=> (hi_q[$past(wr_idx)] == $past(wr_data[HI_W-1:0])));

   // R5: an upper-half write leaves the lower half of that entry alone
   assert_lo_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_hi |=> (lo_q[$past(wr_idx)] == $past(lo_q[wr_idx])));

endmodule

// File: rtl/page_xlate.sv
module page_xlate #(
   parameter int unsigned       LOG_W     = 16,
   parameter int unsigned       SEL_W     = 4,
   parameter int unsigned       FRAME_W   = 12,
   parameter int unsigned       DATA_W    = 8,
   parameter int unsigned       PORT_W    = 8,
   parameter logic [PORT_W-1:0] PORT_BASE = 8'h60,
   parameter bit                INVERT    = 1'b1
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic [LOG_W-1:0]                   cpu_addr,
   input  logic [DATA_W-1:0]                  cpu_data,
   input  logic                               io_req,
   input  logic                               wr_req,
   output logic [FRAME_W+LOG_W-SEL_W-1:0]     phys_addr
);

   localparam int unsigned OFS_W = LOG_W - SEL_W;

   if (PORT_W > LOG_W - SEL_W) begin : g_bad_port
      $error("page_xlate: port number overlaps the entry index bits");
   end

   logic              wr_lo;
   logic              wr_hi;
   logic [SEL_W-1:0]  wr_idx;
   logic [SEL_W-1:0]  page;
   logic [FRAME_W-1:0] frame;

   assign page = cpu_addr[LOG_W-1 -: SEL_W];

   xlate_port_decode #(
      .SEL_W     (SEL_W),
      .PORT_W    (PORT_W),
      .PORT_BASE (PORT_BASE)
   ) u_decode (
      .clk    (clk),
      .rst_n  (rst_n),
      .io_req (io_req),
      .wr_req (wr_req),
      .port   (cpu_addr[PORT_W-1:0]),
      .sel_in (page),
      .wr_lo  (wr_lo),
      .wr_hi  (wr_hi),
      .wr_idx (wr_idx)
   );

   xlate_frame_table #(
      .SEL_W   (SEL_W),
      .FRAME_W (FRAME_W),
      .DATA_W  (DATA_W),
      .INVERT  (INVERT)
   ) u_table (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_lo    (wr_lo),
      .wr_hi    (wr_hi),
      .wr_idx   (wr_idx),
      .wr_data  (cpu_data),
      .rd_idx   (page),
      .rd_frame (frame)
   );

   assign phys_addr = {frame, cpu_addr[OFS_W-1:0]};

   // R8: a low-half write to the page now addressed is visible at once
   assert_visible_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_lo ##1 (page == $past(wr_idx))) |->
         (phys_addr[OFS_W +: DATA_W] ==
          (INVERT ? ~$past(cpu_data) : $past(cpu_data))));

   // R1: with no write and a steady address the output holds
   assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(!wr_lo && !wr_hi) && $stable(cpu_addr)) |-> $stable(phys_addr));

endmodule

// File: tb/sim_page_xlate.sv
module sim_page_xlate;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] cpu_addr = '0;
   logic [7:0]  cpu_data = '0;
   logic        io_req = 1'b0;
   logic        wr_req = 1'b0;
   logic [23:0] phys_addr;

   always #10 clk = ~clk;

   page_xlate u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .cpu_addr  (cpu_addr),
      .cpu_data  (cpu_data),
      .io_req    (io_req),
      .wr_req    (wr_req),
      .phys_addr (phys_addr)
   );

   typedef struct {
      logic [23:0] exp;
      logic [23:0] mask;
      string       tag;
   } item_t;

   item_t       sb_q[$];
   logic [11:0] model [16];
   int          n_checks = 0;
   int          n_errors = 0;
   int          cycles = 0;
   bit          finished = 1'b0;

   // monitor: pops one expected item per rising edge
   always @(posedge clk) begin
      if (sb_q.size() > 0) begin
         item_t it;
         it = sb_q.pop_front();
         n_checks++;
         if ((phys_addr & it.mask) !== (it.exp & it.mask)) begin
            n_errors++;
            $display("FAIL %s: phys_addr=%06h expected=%06h (mask %06h)",
                     it.tag, phys_addr & it.mask, it.exp & it.mask, it.mask);
         end
      end
   end

   // raw I/O cycle; every task starts and ends just after a falling edge
   task automatic io_cycle(input logic [7:0] port, input logic [3:0] idx,
                           input logic [3:0] junk, input logic [7:0] d,
                           input logic iorq, input logic wr);
      cpu_addr = {idx, junk, port};
      cpu_data = d;
      io_req   = iorq;
      wr_req   = wr;
      @(negedge clk);
      io_req   = 1'b0;
      wr_req   = 1'b0;
   endtask

   task automatic set_frame(input logic [3:0] idx, input logic [11:0] f);
      io_cycle(8'h60, idx, 4'hA, ~f[7:0], 1'b1, 1'b1);
      io_cycle(8'h61, idx, 4'h5, {4'hC, ~f[11:8]}, 1'b1, 1'b1);
      model[idx] = f;
   endtask

   task automatic lookup(input logic [15:0] a, input string tag);
      item_t it;
      cpu_addr = a;
      it.exp   = {model[a[15:12]], a[11:0]};
      it.mask  = 24'hFFFFFF;
      it.tag   = tag;
      sb_q.push_back(it);
      @(negedge clk);
   endtask

   task automatic walk(input string tag);
      for (int p = 0; p < 16; p++)
         lookup({p[3:0], 12'h3C5 ^ {p[3:0], p[7:0]}}, tag);
   endtask

   initial begin
      item_t it;
      @(negedge clk);
      // R2: offset passes through while the table is still unloaded
      for (int k = 0; k < 3; k++) begin
         cpu_addr = 16'h7000 + 16'(k * 16'h0123);
         it.exp  = {12'h000, cpu_addr[11:0]};
         it.mask = 24'h000FFF;
         it.tag  = "R2 offset in reset";
         sb_q.push_back(it);
         @(negedge clk);
      end
      rst_n = 1'b1;
      @(negedge clk);

      // R3 R4 R6: identity map loaded by stepping the index
      for (int p = 0; p < 16; p++) set_frame(p[3:0], 12'(p));
      walk("R3 R6 identity map");

      // R1 R6: extreme frame values
      set_frame(4'h0, 12'h000);
      set_frame(4'hF, 12'hFFF);
      set_frame(4'h5, 12'hABC);
      set_frame(4'hA, 12'h35A);
      walk("R1 R6 mixed frames");

      // R5: low half only, upper half of the entry must persist
      io_cycle(8'h60, 4'h3, 4'h0, ~8'h5A, 1'b1, 1'b1);
      model[3][7:0] = 8'h5A;
      lookup(16'h3FFF, "R5 low-half write");
      lookup(16'h4001, "R5 neighbour untouched");

      // R4 R5: upper half only, junk in data[7:4] ignored
      io_cycle(8'h61, 4'h5, 4'h0, 8'hF2, 1'b1, 1'b1);
      model[5][11:8] = 4'hD;
      lookup(16'h5123, "R4 upper-half write");
      lookup(16'h6123, "R5 neighbour untouched");

      // R3: bits [11:8] of the address play no part in the index
      io_cycle(8'h60, 4'h2, 4'h7, ~8'h99, 1'b1, 1'b1);
      model[2][7:0] = 8'h99;
      lookup(16'h2010, "R3 index from top bits");
      lookup(16'h7010, "R3 entry 7 untouched");

      // R7: unqualified and mismatched cycles
      io_cycle(8'h60, 4'h6, 4'h0, 8'h00, 1'b1, 1'b0);
      io_cycle(8'h61, 4'h6, 4'h0, 8'h00, 1'b0, 1'b1);
      io_cycle(8'h62, 4'h6, 4'h0, 8'h00, 1'b1, 1'b1);
      io_cycle(8'h5F, 4'h6, 4'h0, 8'h00, 1'b1, 1'b1);
      lookup(16'h6ABC, "R7 blocked cycles");

      // R7: writes blocked while reset is low; reset keeps the table
      rst_n = 1'b0;
      io_cycle(8'h60, 4'h8, 4'h0, 8'h00, 1'b1, 1'b1);
      io_cycle(8'h61, 4'h8, 4'h0, 8'h00, 1'b1, 1'b1);
      rst_n = 1'b1;
      @(negedge clk);
      lookup(16'h8765, "R7 write during reset");
      walk("R7 table kept over reset");

      // R8: new mapping visible in the first cycle after the write edge
      io_cycle(8'h60, 4'h9, 4'h0, ~8'hE1, 1'b1, 1'b1);
      model[9][7:0] = 8'hE1;
      lookup(16'h9004, "R8 immediate low");
      io_cycle(8'h61, 4'h9, 4'h0, 8'h0B, 1'b1, 1'b1);
      model[9][11:8] = 4'h4;
      lookup(16'h9FF0, "R8 immediate high");

      @(negedge clk);
      finished = 1'b1;
   end

   initial begin
      while (!finished && cycles < 200000) begin
         @(posedge clk);
         cycles++;
      end
      if (!finished) begin
         n_errors++;
         n_checks++;
         $display("FAIL watchdog: cycles=%0d expected completion", cycles);
      end
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

endmodule